// File: doc/BRIEF.md
# Integer Execution Unit with Signed-Overflow Trap

This block is the purely combinational integer execution stage of a 64-bit load-store RISC pipeline. Each cycle the decode stage presents two register operands, a 16-bit immediate taken from the instruction, a 5-bit constant shift count and a 4-bit operation code. The unit returns one 64-bit result and a single trap flag, within the same cycle.

Addition and subtraction exist in two flavours. The trapping flavour raises the flag when the two's-complement result does not fit. The wrapping flavour never raises it. In both cases the result port carries the wrapped value, and the surrounding pipeline decides whether to commit it. The unit also covers bitwise AND and OR, constant logical shifts of the first operand, building the upper half of a word from an immediate, and a signed less-than test that yields 0 or 1. Register storage, fetch, decode, memory, floating point and the response to a trap all live outside this block.

Top module: `int_alu`

## Requirements
- R1: Codes 0 (add) and 2 (subtract) return a+b and a-b modulo 2^64, and raise the trap flag exactly when the true signed result lies outside the signed 64-bit range. The result port still carries the wrapped value.
- R2: Codes 1 (add, wrapping), 3 (subtract, wrapping) and 5 (add immediate, wrapping) return the same modular results as their trapping counterparts, and never raise the trap flag.
- R3: Code 4 (add immediate, trapping) adds the sign-extended 16-bit immediate to operand a, and raises the trap flag on signed overflow. Code 5 uses the same sign-extended immediate.
- R4: Codes 6 (AND) and 7 (OR) return the bitwise AND and the bitwise OR of a and b.
- R5: Codes 8 (AND immediate) and 9 (OR immediate) combine operand a with the immediate zero-extended to 64 bits, so bits 63:16 of the AND-immediate result are always 0.
- R6: Codes 10 (shift left) and 11 (shift right) shift operand a by the 5-bit shift count, 0 to 31 places, and fill the vacated positions with zeros.
- R7: Code 12 (load upper) places the immediate in bits 31:16, clears bits 15:0, and copies bit 31 into bits 63:32.
- R8: Codes 13 (less-than) and 14 (less-than immediate, with the immediate sign-extended) compare operand a against the second value as signed numbers. They return 1 if a is smaller and 0 otherwise.
- R9: Code 15 is unassigned and returns 0 with the trap flag low. No code other than 0, 2 and 4 ever raises the trap flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (encodings listed in the requirements) |
| opnd_a | input | 64 | First source operand; also the value that is shifted |
| opnd_b | input | 64 | Second source operand for the register-register forms |
| shamt | input | 5 | Constant shift count |
| imm | input | 16 | Immediate field of the instruction |
| result | output | 64 | Operation result |
| ovf_trap | output | 1 | Signed-overflow trap request |

## Verification
The bench builds the unit with its default widths: a 64-bit datapath, a 5-bit shift count and a 16-bit immediate. The widths are left at these values because they are the instruction-field sizes, and shrinking them would remove the load-upper placement that depends on them. The bench sweeps every one of the 16 operation codes over a set of corner operands: zero, one, all ones, the most positive and most negative values, and alternating patterns. Each combination is paired with several immediates of both signs, and the shift count rotates through all 32 values. This brings every overflow boundary, every sign-extension choice and every shift distance within reach. The expected values come from 65-bit signed arithmetic and from native shifts in the bench.

// File: rtl/int_alu_pkg.sv
// Package: shared operation codes for the integer execution unit.
// Assumes a 4-bit operation field; code 15 is left unassigned.
package int_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD_T   = 4'd0,
        OP_ADD_W   = 4'd1,
        OP_SUB_T   = 4'd2,
        OP_SUB_W   = 4'd3,
        OP_ADDI_T  = 4'd4,
        OP_ADDI_W  = 4'd5,
        OP_AND     = 4'd6,
        OP_OR      = 4'd7,
        OP_ANDI    = 4'd8,
        OP_ORI     = 4'd9,
        OP_SHL     = 4'd10,
        OP_SHR     = 4'd11,
        OP_LDUP    = 4'd12,
        OP_LESS    = 4'd13,
        OP_LESSI   = 4'd14,
        OP_UNUSED  = 4'd15
    } alu_op_e;

endpackage

// File: rtl/alu_imm_ext.sv
// Immediate widener: produces sign- and zero-extended copies of the
// instruction immediate. Assumes DATA_W > IMM_W.
module alu_imm_ext #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 16
) (
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] imm_sx,
    output logic [DATA_W-1:0] imm_zx
);
    localparam int PAD_W = DATA_W - IMM_W;

    // Replicate the top immediate bit, or pad with zeros.
    always_comb begin
        imm_sx = {{PAD_W{imm[IMM_W-1]}}, imm};
        imm_zx = {{PAD_W{1'b0}}, imm};
    end

endmodule

// File: rtl/alu_addsub.sv
// Shared adder/subtractor. It returns the modular sum and a signed-overflow
// indication. Subtraction is done as a + ~b + 1. Assumes two's-complement operands.
module alu_addsub #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;

    // Invert the second operand for subtraction and add with carry-in.
    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + {{(DATA_W-1){1'b0}}, sub};
    end

    // Overflow: inputs agree in sign, but the sum disagrees.
    always_comb begin
        ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end

endmodule

// File: rtl/alu_shift.sv
// Logical barrel shifter: left and right shift of one operand by an
// unsigned count, zero fill. One stage per count bit, built by generate.
module alu_shift #(
    parameter int DATA_W  = 64,
    parameter int SHAMT_W = 5
) (
    input  logic [DATA_W-1:0]  din,
    input  logic [SHAMT_W-1:0] cnt,
    output logic [DATA_W-1:0]  shl,
    output logic [DATA_W-1:0]  shr
);
    logic [DATA_W-1:0] lst [0:SHAMT_W];
    logic [DATA_W-1:0] rst [0:SHAMT_W];

    assign lst[0] = din;
    assign rst[0] = din;

    generate
        for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
            // Stage k moves by 2^k places when count bit k is set.
            assign lst[k+1] = cnt[k] ? (lst[k] << (1 << k)) : lst[k];
            assign rst[k+1] = cnt[k] ? (rst[k] >> (1 << k)) : rst[k];
        end
    endgenerate

    assign shl = lst[SHAMT_W];
    assign shr = rst[SHAMT_W];

    // Check that the vacated end bits come out zero for any nonzero count.
    always_comb begin
        if (cnt != '0) begin
            AST_SHIFT_ZERO_FILL: assert (shl[0] == 1'b0 && shr[DATA_W-1] == 1'b0); // R6
        end
    end

endmodule

// File: rtl/alu_logic.sv
// Bitwise unit: AND and OR of operand a with a selected second value.
module alu_logic #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] and_o,
    output logic [DATA_W-1:0] or_o
);
    // Plain bitwise combination.
    always_comb begin
        and_o = a & b;
        or_o  = a | b;
    end

endmodule

// File: rtl/int_alu.sv
// Integer execution unit (top). Purely combinational. It decodes the
// operation code, selects the second operand (register, sign-extended or
// zero-extended immediate), and muxes the result of the shared
// adder, shifter and bitwise unit. The trap flag is only raised; the
// pipeline acts on it. Assumes DATA_W >= 32 and IMM_W + 16 <= DATA_W.
module int_alu
    import int_alu_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int SHAMT_W = 5,
    parameter int IMM_W   = 16
) (
    input  logic [3:0]         op_sel,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [IMM_W-1:0]   imm,
    output logic [DATA_W-1:0]  result,
    output logic               ovf_trap
);
    localparam int MSB     = DATA_W - 1;
    localparam int UPPER_S = 16;

    alu_op_e           op;
    logic [DATA_W-1:0] imm_sx, imm_zx;
    logic [DATA_W-1:0] arith_b, logic_b;
    logic              do_sub, trap_op;
    logic [DATA_W-1:0] sum;
    logic              ovf;
    logic [DATA_W-1:0] and_r, or_r, shl_r, shr_r;
    logic              less;

    assign op = alu_op_e'(op_sel);

    alu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_imm (
        .imm    (imm),
        .imm_sx (imm_sx),
        .imm_zx (imm_zx)
    );

    // Operand-b selection and subtract/trap decode.
    always_comb begin
        arith_b = opnd_b;
        logic_b = opnd_b;
        do_sub  = 1'b0;
        trap_op = 1'b0;
        case (op)
            OP_ADD_T:             trap_op = 1'b1;
            OP_SUB_T:  begin do_sub = 1'b1; trap_op = 1'b1; end
            OP_SUB_W, OP_LESS:    do_sub = 1'b1;
            OP_ADDI_T: begin arith_b = imm_sx; trap_op = 1'b1; end
            OP_ADDI_W:            arith_b = imm_sx;
            OP_LESSI:  begin arith_b = imm_sx; do_sub = 1'b1; end
            OP_ANDI, OP_ORI:      logic_b = imm_zx;
            default: ;
        endcase
    end

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a   (opnd_a),
        .b   (arith_b),
        .sub (do_sub),
        .sum (sum),
        .ovf (ovf)
    );

    alu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
        .din (opnd_a),
        .cnt (shamt),
        .shl (shl_r),
        .shr (shr_r)
    );

    alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a     (opnd_a),
        .b     (logic_b),
        .and_o (and_r),
        .or_o  (or_r)
    );

    // Signed less-than from the difference sign corrected by overflow.
    assign less = sum[MSB] ^ ovf;

    // Result selection.
    always_comb begin
        case (op)
            OP_ADD_T, OP_ADD_W, OP_SUB_T, OP_SUB_W,
            OP_ADDI_T, OP_ADDI_W: result = sum;
            OP_AND, OP_ANDI:      result = and_r;
            OP_OR, OP_ORI:        result = or_r;
            OP_SHL:               result = shl_r;
            OP_SHR:               result = shr_r;
            OP_LDUP:              result = imm_sx << UPPER_S;
            OP_LESS, OP_LESSI:    result = {{(DATA_W-1){1'b0}}, less};
            default:              result = '0;
        endcase
    end

    // Trap request only for the trapping arithmetic codes.
    assign ovf_trap = ovf & trap_op;

    // Port-level consistency checks.
    always_comb begin
        if (op == OP_ADD_W || op == OP_SUB_W || op == OP_ADDI_W) begin
            AST_WRAP_NO_TRAP: assert (!ovf_trap); // R2
        end
        if (ovf_trap) begin
            AST_TRAP_SIGN_FLIP: assert (result[MSB] != opnd_a[MSB]); // R1
        end
        if (op == OP_ANDI) begin
            AST_ANDI_HIGH_CLEAR: assert (result[MSB:IMM_W] == '0); // R5
        end
        if (op == OP_LDUP) begin
            AST_UPPER_LOW_CLEAR: assert (result[UPPER_S-1:0] == '0); // R7
        end
        if (op == OP_LESS || op == OP_LESSI) begin
            AST_LESS_BOOLEAN: assert (result[MSB:1] == '0 && !ovf_trap); // R8
        end
        if (op == OP_UNUSED) begin
            AST_UNUSED_QUIET: assert (result == '0 && !ovf_trap); // R9
        end
    end

endmodule

// File: tb/int_alu_bench.sv
// Sweep bench: all operation codes x corner operands x immediates, with the
// shift count rotating through every value. Expected values computed
// arithmetically here.
module int_alu_bench;

    logic        clk = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [4:0]  shamt  = '0;
    logic [15:0] imm    = '0;
    logic [63:0] result;
    logic        ovf_trap;

    int n_total = 0;
    int n_bad   = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    int_alu u_int_alu (
        .op_sel   (op_sel),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .shamt    (shamt),
        .imm      (imm),
        .result   (result),
        .ovf_trap (ovf_trap)
    );

    logic [63:0] corners [0:7];
    logic [15:0] imms    [0:5];

    function automatic string tag(input logic [3:0] op);
        case (op)
            4'd0, 4'd2:  return "R1";
            4'd1, 4'd3:  return "R2";
            4'd4, 4'd5:  return "R3";
            4'd6, 4'd7:  return "R4";
            4'd8, 4'd9:  return "R5";
            4'd10, 4'd11: return "R6";
            4'd12:       return "R7";
            4'd13, 4'd14: return "R8";
            default:     return "R9";
        endcase
    endfunction

    // Independent model: 65-bit signed arithmetic for overflow.
    task automatic model(input logic [3:0] op, input logic [63:0] a,
                         input logic [63:0] b, input logic [4:0] sh,
                         input logic [15:0] im,
                         output logic [63:0] exp_r, output logic exp_t);
        logic signed [64:0] wide;
        logic [63:0] sx, zx;
        sx = {{48{im[15]}}, im};
        zx = {48'd0, im};
        exp_t = 1'b0;
        wide  = '0;
        case (op)
            4'd0, 4'd1: begin
                wide  = $signed({a[63], a}) + $signed({b[63], b});
                exp_r = a + b;
                exp_t = (op == 4'd0) && (wide > 65'sh0_7FFF_FFFF_FFFF_FFFF || wide < -65'sh0_8000_0000_0000_0000);
            end
            4'd2, 4'd3: begin
                wide  = $signed({a[63], a}) - $signed({b[63], b});
                exp_r = a - b;
                exp_t = (op == 4'd2) && (wide > 65'sh0_7FFF_FFFF_FFFF_FFFF || wide < -65'sh0_8000_0000_0000_0000);
            end
            4'd4, 4'd5: begin
                wide  = $signed({a[63], a}) + $signed({sx[63], sx});
                exp_r = a + sx;
                exp_t = (op == 4'd4) && (wide > 65'sh0_7FFF_FFFF_FFFF_FFFF || wide < -65'sh0_8000_0000_0000_0000);
            end
            4'd6:  exp_r = a & b;
            4'd7:  exp_r = a | b;
            4'd8:  exp_r = a & zx;
            4'd9:  exp_r = a | zx;
            4'd10: exp_r = a << sh;
            4'd11: exp_r = a >> sh;
            4'd12: exp_r = {{32{im[15]}}, im, 16'd0};
            4'd13: exp_r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
            4'd14: exp_r = ($signed(a) < $signed(sx)) ? 64'd1 : 64'd0;
            default: exp_r = '0;
        endcase
    endtask

    task automatic apply_check(input logic [3:0] op, input logic [63:0] a,
                               input logic [63:0] b, input logic [4:0] sh,
                               input logic [15:0] im);
        logic [63:0] er;
        logic        et;
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; shamt = sh; imm = im;
        model(op, a, b, sh, im, er, et);
        @(posedge clk);
        #1;
        n_total++;
        if (result !== er) begin
            n_bad++;
            $display("FAIL %s result op=%0d a=%h b=%h sh=%0d imm=%h actual=%h expected=%h",
                     tag(op), op, a, b, sh, im, result, er);
        end
        n_total++;
        if (ovf_trap !== et) begin
            n_bad++;
            $display("FAIL %s trap op=%0d a=%h b=%h imm=%h actual=%b expected=%b",
                     tag(op), op, a, b, im, ovf_trap, et);
        end
    endtask

    initial begin
        corners[0] = 64'h0;
        corners[1] = 64'h1;
        corners[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        corners[3] = 64'h7FFF_FFFF_FFFF_FFFF;
        corners[4] = 64'h8000_0000_0000_0000;
        corners[5] = 64'hAAAA_5555_F0F0_0F0F;
        corners[6] = 64'h7FFF_FFFF_FFFF_8000;
        corners[7] = 64'h8000_0000_0000_7FFF;
        imms[0] = 16'h0000;
        imms[1] = 16'h0001;
        imms[2] = 16'hFFFF;
        imms[3] = 16'h7FFF;
        imms[4] = 16'h8000;
        imms[5] = 16'hA5C3;

        // Quiescent state: unassigned code with zero inputs (R9).
        apply_check(4'd15, 64'd0, 64'd0, 5'd0, 16'd0);
        // Explicit boundary cases: trapping vs wrapping at the top (R1, R2).
        apply_check(4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 5'd0, 16'd0);
        apply_check(4'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 5'd0, 16'd0);
        // ADDI most positive + 1 through the immediate (R3).
        apply_check(4'd4, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 5'd0, 16'h0001);
        // Load upper with a negative immediate (R7).
        apply_check(4'd12, 64'd0, 64'd0, 5'd0, 16'h8001);

        begin
            int rot;
            rot = 0;
            for (int op = 0; op < 16; op++) begin
                for (int i = 0; i < 8; i++) begin
                    for (int j = 0; j < 8; j++) begin
                        for (int k = 0; k < 6; k++) begin
                            apply_check(op[3:0], corners[i], corners[j], rot[4:0], imms[k]);
                            rot++;
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_bad++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

endmodule